// File: doc/BRIEF.md
# Selectable Clock Output Controller

This block places a derived clock on a shared port pin. A single byte-wide control register selects the clock. With the enable bit clear, the pin stays with its general-purpose or alternate-function path (`alt_out`, `alt_oe`). With the enable bit set, the block takes the pin and drives it push-pull with one of two clocks. The first is the system clock divided by an even ratio of 2, 4, 6 or 8. The second is a square wave built from an external pulse train that marks sixteen times the serial baud rate. The register can be read at all times on `rd_data`. A write to it lands only after a timed-access unlock: 0xAA and then 0x55 go to the unlock address, and the protected write must follow within four cycles. Two prescaler bits, which belong to a neighbouring controller, accept a write only while that controller's software-init flag is high.

There are two state machines. The unlock machine has the states LOCKED, KEY_SEEN and OPEN. LOCKED goes to KEY_SEEN on an unlock write of 0xAA. KEY_SEEN goes to OPEN on an unlock write of 0x55 and back to LOCKED on any other write. OPEN goes back to LOCKED on any write, including the accepted one, or when its 4-cycle window runs out. The output machine has the states OFF, DIVIDE and BAUD. It follows the enable and source bits of the register one cycle later. On each change of state it clears the divider phase and both clock levels. In DIVIDE, a new divide select is picked up only when the output rises. In BAUD, the output toggles on each baud pulse.

Top module: `clkout_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x60, `clk_owner` is 0, and `pad_out`/`pad_oe` follow `alt_out`/`alt_oe`.
- R2: A write to the control register (`wr_sel`=0) changes `rd_data` only when it is preceded by an unlock write (`wr_sel`=1) of 0xAA and then one of 0x55, with no other write between.
- R3: The protected write is accepted in any of the 4 cycles that follow the 0x55 cycle, and rejected in the 5th or any later cycle.
- R4: Any write other than the accepted protected write closes an open window, and each unlock admits only one protected write.
- R5: Bits 6:5 of the register are reserved and always read 1.
- R6: Bits 4:3 take the written value only when `sw_init` is 1. Otherwise they keep their value.
- R7: With bit 0 at 0, `clk_owner` is 0 and the pin follows `alt_out`/`alt_oe`, whatever bit 7 holds.
- R8: With bit 0 at 1, `clk_owner` and `pad_oe` are 1 from the cycle after the register update.
- R9: With bit 0 at 1 and bit 7 at 0, `pad_out` is the system clock divided by 2, 4, 6 or 8 for bits 2:1 = 00, 01, 10, 11, with equal high and low times.
- R10: A change of bits 2:1 while dividing takes effect at the next rising edge of `pad_out`. The phase in progress keeps the old length.
- R11: With bits 0 and 7 both at 1, `pad_out` toggles once on each cycle in which `baud_pulse` is 1 and stays still otherwise, whatever bits 2:1 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 1 = unlock address, 0 = control register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current control register value |
| sw_init | input | 1 | Software-init flag of the neighbouring controller; qualifies bits 4:3 |
| baud_pulse | input | 1 | One-cycle pulses at sixteen times the baud rate |
| alt_out | input | 1 | Pin value from the general-purpose/alternate path |
| alt_oe | input | 1 | Pin enable from the general-purpose/alternate path |
| pad_out | output | 1 | Value driven to the pin |
| pad_oe | output | 1 | Output enable to the pin |
| clk_owner | output | 1 | 1 while this block owns the pin |

## Verification
The unlock machine is exercised with a correct key pair, with an interrupting write placed between the keys and inside the window, with the wrong second key, and with protected writes in the last valid cycle and the first invalid one. These cases separate a correct window from one that is too long, too short or never closes. Every divide code is run and its high and low times are measured on their own, which tells a wrong ratio apart from a wrong duty cycle. A select change is made at the start of a low phase to tell deferred switching from immediate switching. The baud path gets irregular pulse spacing with the divide bits set to a non-zero code, which shows both toggling per pulse and that the divide bits are ignored.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
    localparam int REG_W    = 8;
    localparam int EN_BIT   = 0;
    localparam int SEL_LSB  = 1;
    localparam int SEL_W    = 2;
    localparam int PRE_LSB  = 3;
    localparam int PRE_W    = 2;
    localparam int RSV_LSB  = 5;
    localparam int RSV_W    = 2;
    localparam int SRC_BIT  = 7;

    typedef enum logic [1:0] {
        UL_LOCKED,
        UL_KEY_SEEN,
        UL_OPEN
    } unlock_state_e;

    typedef enum logic [1:0] {
        OUT_OFF,
        OUT_DIVIDE,
        OUT_BAUD
    } out_mode_e;
endpackage

// File: rtl/clkout_unlock.sv
module clkout_unlock
    import clkout_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter int               WINDOW = 4,
    parameter logic [DATA_W-1:0] KEY_A  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_B  = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              grant
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    unlock_state_e     state_q, state_d;
    logic [WIN_W-1:0]  win_q, win_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        unique case (state_q)
            UL_LOCKED: begin
                if (wr_en && wr_sel && wr_data == KEY_A)
                    state_d = UL_KEY_SEEN;
            end
            UL_KEY_SEEN: begin
                if (wr_en) begin
                    if (wr_sel && wr_data == KEY_B) begin
                        state_d = UL_OPEN;
                        win_d   = WIN_W'(WINDOW);
                    end else begin
                        state_d = UL_LOCKED;
                    end
                end
            end
            UL_OPEN: begin
                if (wr_en || win_q == WIN_W'(1))
                    state_d = UL_LOCKED;
                else
                    win_d = win_q - WIN_W'(1);
            end
            default: state_d = UL_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_LOCKED;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
        end
    end

    // outputs
    always_comb begin
        grant = (state_q == UL_OPEN);
    end
endmodule

// File: rtl/clkout_reg.sv
module clkout_reg
    import clkout_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = 8'h60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sw_init,
    output logic [REG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (wr_accept) begin
            q[SRC_BIT]               <= wr_data[SRC_BIT];
            q[RSV_LSB +: RSV_W]      <= '1;
            q[SEL_LSB +: SEL_W]      <= wr_data[SEL_LSB +: SEL_W];
            q[EN_BIT]                <= wr_data[EN_BIT];
            if (sw_init)
                q[PRE_LSB +: PRE_W]  <= wr_data[PRE_LSB +: PRE_W];
        end
    end
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
#(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          baud_src,
    input  logic [SW-1:0] div_sel,
    input  logic          baud_pulse,
    output logic          active,
    output logic          clk_out
);
    localparam int HALF_W = SW + 1;

    out_mode_e          mode_q, mode_d;
    logic [HALF_W-1:0]  cnt_q, half_q, sel_half;
    logic               div_lvl_q, baud_lvl_q;

    always_comb begin
        sel_half = HALF_W'(div_sel) + HALF_W'(1);
        if (!enable)
            mode_d = OUT_OFF;
        else if (baud_src)
            mode_d = OUT_BAUD;
        else
            mode_d = OUT_DIVIDE;
    end

    // state register with divider and baud toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= OUT_OFF;
            cnt_q      <= '0;
            half_q     <= HALF_W'(1);
            div_lvl_q  <= 1'b0;
            baud_lvl_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (mode_q != mode_d) begin
                cnt_q      <= '0;
                half_q     <= sel_half;
                div_lvl_q  <= 1'b0;
                baud_lvl_q <= 1'b0;
            end else begin
                unique case (mode_q)
                    OUT_DIVIDE: begin
                        if (cnt_q == half_q - HALF_W'(1)) begin
                            cnt_q     <= '0;
                            div_lvl_q <= ~div_lvl_q;
                            if (!div_lvl_q)
                                half_q <= sel_half;
                        end else begin
                            cnt_q <= cnt_q + HALF_W'(1);
                        end
                    end
                    OUT_BAUD: begin
                        if (baud_pulse)
                            baud_lvl_q <= ~baud_lvl_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        active  = (mode_q != OUT_OFF);
        unique case (mode_q)
            OUT_DIVIDE: clk_out = div_lvl_q;
            OUT_BAUD:   clk_out = baud_lvl_q;
            default:    clk_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
    import clkout_pkg::*;
#(
    parameter int               WINDOW    = 4,
    parameter logic [REG_W-1:0] KEY_A     = 8'hAA,
    parameter logic [REG_W-1:0] KEY_B     = 8'h55,
    parameter logic [REG_W-1:0] RESET_VAL = 8'h60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             sw_init,
    input  logic             baud_pulse,
    input  logic             alt_out,
    input  logic             alt_oe,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             clk_owner
);
    logic             grant;
    logic             wr_accept;
    logic [REG_W-1:0] ctrl_q;
    logic             gen_active;
    logic             gen_clk;

    clkout_unlock #(
        .DATA_W (REG_W),
        .WINDOW (WINDOW),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) i_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .grant   (grant)
    );

    assign wr_accept = grant && wr_en && !wr_sel;

    clkout_reg #(
        .RESET_VAL (RESET_VAL)
    ) i_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .wr_data   (wr_data),
        .sw_init   (sw_init),
        .q         (ctrl_q)
    );

    clkout_gen #(
        .SW (SEL_W)
    ) i_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctrl_q[EN_BIT]),
        .baud_src   (ctrl_q[SRC_BIT]),
        .div_sel    (ctrl_q[SEL_LSB +: SEL_W]),
        .baud_pulse (baud_pulse),
        .active     (gen_active),
        .clk_out    (gen_clk)
    );

    // pin ownership select
    always_comb begin
        rd_data   = ctrl_q;
        clk_owner = gen_active;
        pad_out   = gen_active ? gen_clk : alt_out;
        pad_oe    = gen_active ? 1'b1    : alt_oe;
    end
endmodule

// File: rtl/clkout_ctrl_sva.sv
module clkout_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] rd_data,
    input logic       sw_init,
    input logic       baud_pulse,
    input logic       alt_out,
    input logic       alt_oe,
    input logic       pad_out,
    input logic       pad_oe,
    input logic       clk_owner
);
    assert_no_unprotected_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_sel) |=> $stable(rd_data));

    assert_reserved_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:5] == 2'b11);

    assert_prescaler_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_init |=> $stable(rd_data[4:3]));

    assert_pin_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[0] && !$past(rd_data[0])) |->
            (!clk_owner && pad_oe == alt_oe && pad_out == alt_out));

    assert_pin_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && $past(rd_data[0])) |-> (clk_owner && pad_oe));

    assert_baud_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && rd_data[7] && $past(rd_data[0]) && $past(rd_data[7]) && !baud_pulse)
            |=> $stable(pad_out));

    assert_baud_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && rd_data[7] && $past(rd_data[0]) && $past(rd_data[7]) && baud_pulse)
            |=> (pad_out != $past(pad_out)));
endmodule

bind clkout_ctrl clkout_ctrl_sva i_clkout_ctrl_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .rd_data    (rd_data),
    .sw_init    (sw_init),
    .baud_pulse (baud_pulse),
    .alt_out    (alt_out),
    .alt_oe     (alt_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .clk_owner  (clk_owner)
);

// File: tb/test_clkout_ctrl.sv
`timescale 1ns/100ps
module test_clkout_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sw_init = 1'b0;
    logic       baud_pulse = 1'b0;
    logic       alt_out = 1'b0;
    logic       alt_oe = 1'b0;
    logic       pad_out, pad_oe, clk_owner;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkout_ctrl i_clkout_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .sw_init(sw_init), .baud_pulse(baud_pulse),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .clk_owner(clk_owner)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_reg = 8'h60;
    int m_stage = 0, m_win = 0, m_mode = 0, m_cnt = 0, m_half = 1, tgt = 0;
    bit m_dlvl = 1'b0, m_blvl = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 8'h60; m_stage = 0; m_win = 0; m_mode = 0;
            m_cnt = 0; m_half = 1; m_dlvl = 1'b0; m_blvl = 1'b0;
        end else begin
            tgt = !m_reg[0] ? 0 : (m_reg[7] ? 2 : 1);
            if (tgt != m_mode) begin
                m_mode = tgt; m_cnt = 0; m_dlvl = 1'b0; m_blvl = 1'b0;
                m_half = int'(m_reg[2:1]) + 1;
            end else if (m_mode == 1) begin
                if (m_cnt == m_half - 1) begin
                    m_cnt = 0;
                    m_dlvl = !m_dlvl;
                    if (m_dlvl) m_half = int'(m_reg[2:1]) + 1;
                end else m_cnt++;
            end else if (m_mode == 2 && baud_pulse) begin
                m_blvl = !m_blvl;
            end
            if (wr_en) begin
                if (wr_sel) begin
                    if (m_stage == 0 && wr_data == 8'hAA) m_stage = 1;
                    else if (m_stage == 1 && wr_data == 8'h55) begin m_stage = 2; m_win = 4; end
                    else m_stage = 0;
                end else begin
                    if (m_stage == 2)
                        m_reg = {wr_data[7], 2'b11, sw_init ? wr_data[4:3] : m_reg[4:3], wr_data[2:0]};
                    m_stage = 0;
                end
            end else if (m_stage == 2) begin
                if (m_win == 1) m_stage = 0; else m_win--;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit e_own, e_oe, e_out;
            e_own = (m_mode != 0);
            e_oe  = e_own ? 1'b1 : alt_oe;
            e_out = (m_mode == 1) ? m_dlvl : (m_mode == 2) ? m_blvl : alt_out;
            check(rd_data == m_reg, "R2 register value", rd_data, m_reg);
            check(clk_owner == e_own && pad_oe == e_oe, "R8 pin ownership",
                  {clk_owner, pad_oe}, {e_own, e_oe});
            check(pad_out == e_out, "R9 pad_out vs model", pad_out, e_out);
        end
    end

    task automatic do_wr(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prot_wr(input logic [7:0] d);
        do_wr(1'b1, 8'hAA);
        do_wr(1'b1, 8'h55);
        do_wr(1'b0, d);
    endtask

    task automatic meas(output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        while (pad_out != 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        while (pad_out != 1'b1 && guard < 100) begin @(negedge clk); guard++; end
        while (pad_out == 1'b1 && guard < 100) begin hi++; @(negedge clk); guard++; end
        while (pad_out == 1'b0 && guard < 100) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic pulse();
        baud_pulse = 1'b1;
        @(negedge clk);
        baud_pulse = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int hi, lo;
        bit lvl;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        alt_oe = 1'b1; alt_out = 1'b1;
        #1;
        check(rd_data == 8'h60, "R1 reset value", rd_data, 8'h60);
        check(!clk_owner && pad_out == 1'b1 && pad_oe == 1'b1, "R1 pin released",
              {clk_owner, pad_out, pad_oe}, 3'b011);
        @(negedge clk);
        // R2 plain write without unlock
        do_wr(1'b0, 8'h01); idle(1);
        check(rd_data == 8'h60, "R2 write without unlock ignored", rd_data, 8'h60);
        // R4 interrupting write between keys
        do_wr(1'b1, 8'hAA); do_wr(1'b0, 8'h00); do_wr(1'b1, 8'h55); do_wr(1'b0, 8'h01); idle(1);
        check(rd_data == 8'h60, "R4 interrupted key pair", rd_data, 8'h60);
        // R2 wrong second key
        do_wr(1'b1, 8'hAA); do_wr(1'b1, 8'h56); do_wr(1'b0, 8'h01); idle(1);
        check(rd_data == 8'h60, "R2 wrong second key", rd_data, 8'h60);
        // R4 unlock-address write inside the window closes it
        do_wr(1'b1, 8'hAA); do_wr(1'b1, 8'h55); do_wr(1'b1, 8'h00); do_wr(1'b0, 8'h01); idle(1);
        check(rd_data == 8'h60, "R4 window closed by other write", rd_data, 8'h60);
        // R3 fifth cycle rejected
        do_wr(1'b1, 8'hAA); do_wr(1'b1, 8'h55); idle(4); do_wr(1'b0, 8'h01); idle(1);
        check(rd_data == 8'h60, "R3 fifth cycle rejected", rd_data, 8'h60);
        // R3 fourth cycle accepted; R7 source bit without enable
        do_wr(1'b1, 8'hAA); do_wr(1'b1, 8'h55); idle(3); do_wr(1'b0, 8'h80); idle(1);
        check(rd_data == 8'hE0, "R3 fourth cycle accepted", rd_data, 8'hE0);
        alt_out = 1'b0; alt_oe = 1'b0; #1;
        check(!clk_owner && pad_out == 1'b0 && pad_oe == 1'b0, "R7 bit7 alone has no effect",
              {clk_owner, pad_out, pad_oe}, 3'b000);
        @(negedge clk);
        // R4 one write per unlock
        prot_wr(8'h00); do_wr(1'b0, 8'h81); idle(1);
        check(rd_data == 8'h60, "R4 second write after unlock rejected", rd_data, 8'h60);
        // R5 reserved bits, R6 prescaler guard
        prot_wr(8'h18); idle(1);
        check(rd_data == 8'h60, "R5 R6 reserved set, prescaler guarded", rd_data, 8'h60);
        sw_init = 1'b1;
        prot_wr(8'h18); idle(1);
        check(rd_data == 8'h78, "R6 prescaler written with sw_init", rd_data, 8'h78);
        prot_wr(8'h00); idle(1);
        check(rd_data == 8'h60, "R6 prescaler cleared with sw_init", rd_data, 8'h60);
        sw_init = 1'b0;
        // R9 all ratios
        for (int code = 0; code < 4; code++) begin
            prot_wr(8'(code * 2 + 1));
            idle(2);
            check(clk_owner && pad_oe, "R8 owner after enable", {clk_owner, pad_oe}, 2'b11);
            meas(hi, lo);
            check(hi == code + 1 && lo == code + 1, "R9 divide high/low",
                  hi * 16 + lo, (code + 1) * 17);
        end
        // R10 change select at start of a low phase (/8 -> /2)
        lvl = pad_out;
        while (!(lvl == 1'b1 && pad_out == 1'b0)) begin lvl = pad_out; @(negedge clk); end
        prot_wr(8'h01);
        check(pad_out == 1'b0, "R10 low phase keeps old length", pad_out, 0);
        @(negedge clk);
        check(pad_out == 1'b1, "R10 rises after old low", pad_out, 1);
        meas(hi, lo);
        check(hi == 1 && lo == 1, "R10 new ratio after rising edge", hi * 16 + lo, 17);
        // R11 baud source, divide bits non-zero
        prot_wr(8'h87); idle(2);
        lvl = pad_out;
        pulse();
        check(pad_out == !lvl, "R11 toggles on pulse", pad_out, !lvl);
        idle(3);
        check(pad_out == !lvl, "R11 holds without pulse", pad_out, !lvl);
        pulse(); pulse();
        check(pad_out == !lvl, "R11 two pulses restore", pad_out, !lvl);
        idle(1); pulse();
        check(pad_out == lvl, "R11 spaced pulse", pad_out, lvl);
        // R7 disable returns pin
        prot_wr(8'h00); idle(2);
        alt_out = 1'b1; alt_oe = 1'b1; #1;
        check(!clk_owner && pad_out == 1'b1 && pad_oe == 1'b1, "R7 pin returned",
              {clk_owner, pad_out, pad_oe}, 3'b011);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule